// File: doc/BRIEF.md
# Selective Multi-Lane Symbol Scrambler

This block whitens the 8-bit symbols of a multi-lane serial link before line coding. Each lane has a 16-bit pseudo-random generator whose output byte is XORed onto ordinary data symbols. Control symbols, data that belongs to ordered sets, and compliance-pattern symbols pass through unchanged. A comma control symbol reloads the generator with all ones, so that the two ends of the link start from the same state. A skip control symbol leaves the generator where it is. The same block descrambles at the receiver, because XORing the same key a second time restores the symbol.

Symbols arrive one beat at a time. Each beat carries one symbol per lane, with a control flag, an ordered-set flag and a compliance flag for every lane. The beat leaves one cycle later through a registered valid/ready output stage. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or is being emptied in the same cycle. While `out_ready` is low, the held output beat stays frozen and no generator advances. The plain input `scr_enable` turns the XOR off for test, while the generators keep stepping and reloading.

Every lane has its own generator, driven only by its own lane's flags. Lanes stay in lockstep because ordered sets, and therefore commas and skips, arrive on all lanes in the same beat.

Top module: `scr_multilane`

## Requirements
- R1: After reset `out_valid` is 0 and every lane's generator holds FFFFh, so the first ordinary data symbol on each lane is XORed with the key derived from FFFFh.
- R2: The generator steps in Galois form: one step outputs bit 15 as the serial bit, shifts the state left by one, and XORs in 0039h when that bit was 1 (polynomial x^16+x^5+x^4+x^3+1). Each symbol takes 8 steps. The first serial bit lands on data bit 0, and an ordinary data symbol (control flag 0, ordered-set flag 0, compliance flag 0) with `scr_enable` high leaves as symbol XOR that key.
- R3: A control symbol other than comma (BCh) and skip (1Ch) passes through unchanged, with its control flag copied to `out_is_k`, and its lane's generator still advances 8 steps.
- R4: A data symbol with its ordered-set flag or its compliance flag set passes through unchanged, and its lane's generator still advances 8 steps.
- R5: A comma (control flag 1, value BCh) passes through unchanged and reloads its lane's generator to FFFFh.
- R6: A skip (control flag 1, value 1Ch) passes through unchanged and leaves its lane's generator unchanged.
- R7: With `scr_enable` low every symbol passes through unchanged, while the generators advance and reload exactly as with scrambling on.
- R8: While `out_valid` is high and `out_ready` is low, the output beat stays stable, `in_ready` is low, and no generator changes.
- R9: Each lane's scrambling depends only on that lane's own symbol history, so lanes with different flags in the same beat are treated independently.
- R10: A beat accepted at a clock edge appears on the output right after that edge, and `in_ready` equals NOT `out_valid` OR `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_enable | input | 1 | 1 = scramble eligible data, 0 = test bypass |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_sym | input | NUM_LANES*8 | Input symbols, lane n in bits [8n+7:8n] |
| in_is_k | input | NUM_LANES | Per-lane control-symbol flag |
| in_os | input | NUM_LANES | Per-lane ordered-set data flag |
| in_comp | input | NUM_LANES | Per-lane compliance-pattern flag |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_sym | output | NUM_LANES*8 | Output symbols, same lane layout |
| out_is_k | output | NUM_LANES | Control flags passed through |

## Verification
The bench builds the block with its default of four lanes. With four lanes, one beat can mix commas, skips, flagged data and ordinary data across lanes, so separate generator states and their divergence (R9) can be observed on a single output bus. The bench also varies stalls on both sides, which shows that stalled cycles leave every lane's key sequence untouched.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int SYM_W   = 8;
  localparam int LFSR_W  = 16;
  localparam logic [SYM_W-1:0]  COMMA_CODE = 8'hBC;
  localparam logic [SYM_W-1:0]  SKIP_CODE  = 8'h1C;
  localparam logic [LFSR_W-1:0] LFSR_SEED  = 16'hFFFF;
  localparam logic [LFSR_W-1:0] LFSR_TAPS  = 16'h0039;

  typedef enum logic [1:0] {
    GEN_STEP   = 2'd0,
    GEN_RELOAD = 2'd1,
    GEN_HOLD   = 2'd2
  } gen_act_e;

  typedef struct packed {
    logic [SYM_W-1:0]  key;
    logic [LFSR_W-1:0] next;
  } gen_out_t;

  // Runs the generator for one symbol time; serial bit k drives key bit k.
  function automatic gen_out_t gen_run(input logic [LFSR_W-1:0] cur);
    gen_out_t r;
    logic [LFSR_W-1:0] s;
    logic b;
    s = cur;
    r.key = '0;
    for (int k = 0; k < SYM_W; k++) begin
      b = s[LFSR_W-1];
      r.key[k] = b;
      s = {s[LFSR_W-2:0], 1'b0} ^ (b ? LFSR_TAPS : '0);
    end
    r.next = s;
    return r;
  endfunction
endpackage

// File: rtl/scr_lane_class.sv
module scr_lane_class
  import scr_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  input  logic             is_k,
  input  logic             os_flag,
  input  logic             comp_flag,
  input  logic             enable,
  output gen_act_e         act,
  output logic             mix_en
);
  logic is_comma, is_skip;

  always_comb begin
    is_comma = is_k && (sym == COMMA_CODE);
    is_skip  = is_k && (sym == SKIP_CODE);
    if (is_comma)     act = GEN_RELOAD;
    else if (is_skip) act = GEN_HOLD;
    else              act = GEN_STEP;
    mix_en = enable && !is_k && !os_flag && !comp_flag;
  end
endmodule

// File: rtl/scr_lane_gen.sv
module scr_lane_gen
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  gen_act_e         act,
  output logic [SYM_W-1:0] key
);
  logic [LFSR_W-1:0] state_q;
  gen_out_t          run;

  always_comb run = gen_run(state_q);
  assign key = run.key;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LFSR_SEED;
    end else if (take) begin
      case (act)
        GEN_RELOAD: state_q <= LFSR_SEED;
        GEN_HOLD:   state_q <= state_q;
        default:    state_q <= run.next;
      endcase
    end
  end
endmodule

// File: rtl/scr_multilane.sv
module scr_multilane
  import scr_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scr_enable,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NUM_LANES*SYM_W-1:0] in_sym,
  input  logic [NUM_LANES-1:0]       in_is_k,
  input  logic [NUM_LANES-1:0]       in_os,
  input  logic [NUM_LANES-1:0]       in_comp,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NUM_LANES*SYM_W-1:0] out_sym,
  output logic [NUM_LANES-1:0]       out_is_k
);
  localparam int BUS_W = NUM_LANES * SYM_W;

  logic             take;
  logic [BUS_W-1:0] nxt_sym;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    gen_act_e         act;
    logic             mix_en;
    logic [SYM_W-1:0] key;

    scr_lane_class u_class (
      .sym       (in_sym[ln*SYM_W +: SYM_W]),
      .is_k      (in_is_k[ln]),
      .os_flag   (in_os[ln]),
      .comp_flag (in_comp[ln]),
      .enable    (scr_enable),
      .act       (act),
      .mix_en    (mix_en)
    );

    scr_lane_gen u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .act   (act),
      .key   (key)
    );

    assign nxt_sym[ln*SYM_W +: SYM_W] =
      in_sym[ln*SYM_W +: SYM_W] ^ (mix_en ? key : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_is_k  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sym   <= nxt_sym;
      out_is_k  <= in_is_k;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/scr_multilane_chk.sv
module scr_multilane_chk
  import scr_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scr_enable,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [NUM_LANES*SYM_W-1:0] in_sym,
  input logic [NUM_LANES-1:0]       in_is_k,
  input logic [NUM_LANES-1:0]       in_os,
  input logic [NUM_LANES-1:0]       in_comp,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [NUM_LANES*SYM_W-1:0] out_sym,
  input logic [NUM_LANES-1:0]       out_is_k
);
  // R8: a stalled output beat is frozen
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_is_k)));

  // R8: a full, stalled output register refuses input
  a_r8_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: an accepted beat is on the output one cycle later
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R3: control flags travel with their beat
  a_r3_flag_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_is_k == $past(in_is_k)));

  // R4 / R7: bypassed lanes leave unchanged
  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_pass
    a_r4_bypass_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready &&
       (in_is_k[ln] || in_os[ln] || in_comp[ln] || !scr_enable))
      |=> (out_sym[ln*SYM_W +: SYM_W] == $past(in_sym[ln*SYM_W +: SYM_W])));
  end
endmodule

bind scr_multilane scr_multilane_chk #(.NUM_LANES(NUM_LANES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .scr_enable (scr_enable),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sym     (in_sym),
  .in_is_k    (in_is_k),
  .in_os      (in_os),
  .in_comp    (in_comp),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sym    (out_sym),
  .out_is_k   (out_is_k)
);

// File: tb/scr_multilane_tb.sv
module scr_multilane_tb_top;
  localparam int L = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           scr_enable = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [L*8-1:0] in_sym = '0;
  logic [L-1:0]   in_is_k = '0;
  logic [L-1:0]   in_os = '0;
  logic [L-1:0]   in_comp = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [L*8-1:0] out_sym;
  logic [L-1:0]   out_is_k;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int unsigned    ref_gen [L];
  bit             exp_valid;
  logic [L*8-1:0] exp_sym;
  logic [L-1:0]   exp_k;
  int             beat_no;

  always #10 clk = ~clk;

  scr_multilane #(.NUM_LANES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .scr_enable(scr_enable),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .in_is_k(in_is_k), .in_os(in_os), .in_comp(in_comp),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_is_k(out_is_k)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < L; i++) ref_gen[i] = 32'hFFFF;
    exp_valid = 1'b0;
    exp_sym = '0;
    exp_k = '0;
  endfunction

  // one symbol of one lane through the behavioural reference
  function automatic logic [7:0] model_lane(input int i, input logic [7:0] s,
      input bit k, input bit os, input bit cp, input bit en);
    int unsigned st;
    int unsigned key;
    int unsigned b;
    if (k && s == 8'hBC) begin
      ref_gen[i] = 32'hFFFF;
      return s;
    end
    if (k && s == 8'h1C) return s;
    st = ref_gen[i];
    key = 0;
    for (int n = 0; n < 8; n++) begin
      b = (st >> 15) & 1;
      key = key | (b << n);
      st = (st << 1) & 32'hFFFF;
      if (b != 0) st = st ^ 32'h0039;
    end
    ref_gen[i] = st;
    if (!k && !os && !cp && en) return s ^ key[7:0];
    return s;
  endfunction

  // mode: 0 plain data, 1 control mix, 2 os/comp flags, 3 periodic comma,
  // 4 skips, 5 per-lane mixture
  task automatic drive_beat(input int mode, input bit rnd_valid, input bit rnd_ready);
    logic [7:0] s;
    bit k, os, cp;
    int pick;
    bit all_comma, all_skip;
    all_comma = (mode == 3) && (beat_no % 6 == 0);
    all_skip  = (mode == 4) && ($urandom_range(0, 3) == 0);
    for (int i = 0; i < L; i++) begin
      s = 8'($urandom_range(0, 255));
      k = 1'b0; os = 1'b0; cp = 1'b0;
      case (mode)
        1: begin
          k = 1'($urandom_range(0, 1));
          if (k && (s == 8'hBC || s == 8'h1C)) s = 8'hF7;
        end
        2: begin
          os = 1'($urandom_range(0, 1));
          cp = 1'($urandom_range(0, 1));
        end
        3: if (all_comma) begin k = 1'b1; s = 8'hBC; end
        4: if (all_skip) begin k = 1'b1; s = 8'h1C; end
        5: begin
          pick = $urandom_range(0, 7);
          if (pick == 0) begin k = 1'b1; s = 8'hBC; end
          else if (pick == 1) begin k = 1'b1; s = 8'h1C; end
          else if (pick == 2) begin k = 1'b1; if (s == 8'hBC || s == 8'h1C) s = 8'hFE; end
          else if (pick == 3) os = 1'b1;
          else if (pick == 4) cp = 1'b1;
        end
        default: ;
      endcase
      in_sym[i*8 +: 8] = s;
      in_is_k[i] = k;
      in_os[i] = os;
      in_comp[i] = cp;
    end
    in_valid  = rnd_valid ? 1'($urandom_range(0, 1)) : 1'b1;
    out_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  endtask

  task automatic run_phase(input string tag, input int n, input int mode,
                           input bit en, input bit rnd_valid, input bit rnd_ready);
    bit exp_rdy, acc;
    scr_enable = en;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      // compare the state the last edge produced (R10 timing)
      check(tag, "out_valid", longint'(out_valid), longint'(exp_valid));
      if (exp_valid) begin
        check(tag, "out_sym", longint'(out_sym), longint'(exp_sym));
        check(tag, "out_is_k", longint'(out_is_k), longint'(exp_k));
      end
      drive_beat(mode, rnd_valid, rnd_ready);
      #1;
      exp_rdy = !exp_valid || out_ready;
      check(tag, "in_ready", longint'(in_ready), longint'(exp_rdy));
      acc = in_valid && exp_rdy;
      if (acc) begin
        beat_no++;
        for (int i = 0; i < L; i++)
          exp_sym[i*8 +: 8] = model_lane(i, in_sym[i*8 +: 8], in_is_k[i],
                                         in_os[i], in_comp[i], en);
        exp_k = in_is_k;
        exp_valid = 1'b1;
      end else if (out_ready) begin
        exp_valid = 1'b0;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      check("R1", "out_valid in reset", longint'(out_valid), 0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    beat_no = 0;
    do_reset();
    run_phase("R1", 4, 0, 1'b1, 1'b0, 1'b0);
    run_phase("R2", 200, 0, 1'b1, 1'b0, 1'b0);
    run_phase("R3", 200, 1, 1'b1, 1'b0, 1'b0);
    run_phase("R4", 200, 2, 1'b1, 1'b0, 1'b0);
    run_phase("R5", 200, 3, 1'b1, 1'b0, 1'b0);
    run_phase("R6", 200, 4, 1'b1, 1'b0, 1'b0);
    run_phase("R7", 200, 5, 1'b0, 1'b0, 1'b0);
    run_phase("R8", 400, 0, 1'b1, 1'b1, 1'b1);
    run_phase("R9", 400, 5, 1'b1, 1'b1, 1'b1);
    run_phase("R10", 200, 5, 1'b1, 1'b0, 1'b1);
    // second reset mid-stream: generators must restart from FFFFh
    do_reset();
    run_phase("R1", 20, 0, 1'b1, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule